// File: doc/BRIEF.md
# Colour Palette Host Access Port

This block is the register port a host uses to load and inspect a 256-entry RGB colour palette and a separate two-entry cursor palette. The host first writes an entry number to a read-index or a write-index address. It then moves colour bytes through one data address, one access per colour component. A read sequence and a write sequence each keep their own component phase and their own index. In main-palette mode the index advances by one after each blue access, so a run of entries can be streamed after a single index write.

An input select line, `cursor_sel`, moves the data address onto the two-entry cursor palette. In that mode only bit 0 of the index counts and the index never advances. The same line also decides what the shared mask/command address reaches. With `cursor_sel` low it reaches the pixel-mask register. With `cursor_sel` high it reaches the converter command register. Both registers are brought out as plain outputs for the neighbouring pixel path.

Host accesses use a request strobe with no ready signal, so the port accepts one access in every cycle. Read data comes back as a single-cycle `rd_valid` pulse. This response has no ready either, so the host must capture it in the cycle it appears and cannot apply back-pressure.

Top module: `pal_port`

## Requirements
- R1: After reset, both index registers read back as 0, both phases are at red, the pixel mask is 8'hFF, the command register is 8'h00 and `rd_valid` is low.
- R2: A write to address 2 loads the write index and returns the write phase to red. The data writes at address 3 that follow store red, green and blue of that entry, in that order. Rewriting the index in the middle of an entry restarts at red.
- R3: A write to address 1 loads the read index and returns the read phase to red. Reads at address 3 then return red, green and blue of that entry, in that order. Every read answers on `rd_data` with `rd_valid` high in the cycle after the access.
- R4: In main-palette mode (`cursor_sel`=0), the index advances by one after the blue access of a read or write sequence, and wraps from 255 to 0.
- R5: Read and write sequences keep separate phases and indices. Accesses in one direction leave the other direction's position unchanged.
- R6: With `cursor_sel`=1, data accesses reach a two-entry cursor palette selected by index bit 0, and the main palette is left unchanged.
- R7: With `cursor_sel`=1, the index does not advance after blue, and the next data access is red of the same entry.
- R8: Address 0 reaches the pixel mask when `cursor_sel`=0 and the command register when `cursor_sel`=1. An access leaves the other register unchanged.
- R9: Reading address 1 returns the read index, and reading address 2 returns the write index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | 0 mask/command, 1 read index, 2 write index, 3 colour data |
| acc_wdata | input | 8 | Write data |
| cursor_sel | input | 1 | Selects the cursor palette and the command register |
| rd_data | output | 8 | Read response data |
| rd_valid | output | 1 | Read response strobe |
| pix_mask | output | 8 | Pixel mask register |
| dac_cmd | output | 8 | Converter command register |

## Verification
A write takes effect at the clock edge that samples the access. Its result is visible to any read issued in the next cycle. A read response, or an index readback that shows an auto-increment, appears on `rd_data` with `rd_valid` one edge after the read access. The bench drives each access on a falling edge and samples the response on the following falling edge, half a period after the edge that registered it. Register outputs such as `pix_mask` are sampled in the same way after the write edge.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    A_MASKCMD = 2'd0,
    A_RIDX    = 2'd1,
    A_WIDX    = 2'd2,
    A_DATA    = 2'd3
  } addr_e;

  localparam int unsigned NUM_COMP = 3;
endpackage

// File: rtl/pal_idx_seq.sv
module pal_idx_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  input  logic             inc_en,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= PH_RED;
    end else if (step) begin
      unique case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        default: begin
          phase <= PH_RED;
          if (inc_en) idx <= idx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  phase_e        wsel,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  phase_e        rsel,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] comp_rd [NUM_COMP];

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [CW-1:0] arr [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wsel == phase_e'(c))) arr[waddr] <= wdata;
    end
    assign comp_rd[c] = arr[raddr];
  end

  always_comb begin
    unique case (rsel)
      PH_RED:  rdata = comp_rd[0];
      PH_GRN:  rdata = comp_rd[1];
      default: rdata = comp_rd[2];
    endcase
  end
endmodule

// File: rtl/pal_port.sv
module pal_port
  import pal_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned CUR_DEPTH  = 2,
  parameter logic [7:0]  MASK_RST   = 8'hFF,
  localparam int unsigned MAIN_DEPTH = 1 << IDX_W,
  localparam int unsigned CUR_AW     = (CUR_DEPTH > 1) ? $clog2(CUR_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [1:0]    acc_addr,
  input  logic [DW-1:0] acc_wdata,
  input  logic          cursor_sel,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [DW-1:0] pix_mask,
  output logic [DW-1:0] dac_cmd
);
  logic       do_wr, do_rd;
  addr_e      addr;
  logic [IDX_W-1:0] widx, ridx;
  phase_e     wphase, rphase;
  logic [DW-1:0] main_rd, cur_rd;

  assign addr  = addr_e'(acc_addr);
  assign do_wr = acc_en &&  acc_wr;
  assign do_rd = acc_en && !acc_wr;

  pal_idx_seq #(.IDX_W(IDX_W)) u_wseq (
    .clk(clk), .rst_n(rst_n),
    .load(do_wr && addr == A_WIDX), .load_val(acc_wdata[IDX_W-1:0]),
    .step(do_wr && addr == A_DATA), .inc_en(!cursor_sel),
    .idx(widx), .phase(wphase)
  );

  pal_idx_seq #(.IDX_W(IDX_W)) u_rseq (
    .clk(clk), .rst_n(rst_n),
    .load(do_wr && addr == A_RIDX), .load_val(acc_wdata[IDX_W-1:0]),
    .step(do_rd && addr == A_DATA), .inc_en(!cursor_sel),
    .idx(ridx), .phase(rphase)
  );

  pal_store #(.DEPTH(MAIN_DEPTH), .CW(DW)) u_main (
    .clk(clk), .we(do_wr && addr == A_DATA && !cursor_sel),
    .waddr(widx), .wsel(wphase), .wdata(acc_wdata),
    .raddr(ridx), .rsel(rphase), .rdata(main_rd)
  );

  pal_store #(.DEPTH(CUR_DEPTH), .CW(DW)) u_cur (
    .clk(clk), .we(do_wr && addr == A_DATA && cursor_sel),
    .waddr(widx[CUR_AW-1:0]), .wsel(wphase), .wdata(acc_wdata),
    .raddr(ridx[CUR_AW-1:0]), .rsel(rphase), .rdata(cur_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_mask <= DW'(MASK_RST);
      dac_cmd  <= '0;
    end else if (do_wr && addr == A_MASKCMD) begin
      if (cursor_sel) dac_cmd  <= acc_wdata;
      else            pix_mask <= acc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) begin
        unique case (addr)
          A_MASKCMD: rd_data <= cursor_sel ? dac_cmd : pix_mask;
          A_RIDX:    rd_data <= DW'(ridx);
          A_WIDX:    rd_data <= DW'(widx);
          default:   rd_data <= cursor_sel ? cur_rd : main_rd;
        endcase
      end
    end
  end
endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [1:0]       acc_addr,
  input logic             cursor_sel,
  input logic             rd_valid,
  input logic [DW-1:0]    pix_mask,
  input logic [DW-1:0]    dac_cmd,
  input logic [IDX_W-1:0] widx,
  input logic [1:0]       wphase,
  input logic [IDX_W-1:0] ridx,
  input logic [1:0]       rphase
);
  logic data_wr, data_rd;
  assign data_wr = acc_en && acc_wr && acc_addr == 2'd3;
  assign data_rd = acc_en && !acc_wr && acc_addr == 2'd3;

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr) |=> rd_valid); // R3
  AST_RD_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> !rd_valid); // R3
  AST_WIDX_LOAD_RED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr == 2'd2) |=> wphase == 2'd0); // R2
  AST_MAIN_WINC: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !cursor_sel && wphase == 2'd2) |=> widx == IDX_W'($past(widx) + 1'b1)); // R4
  AST_MAIN_RINC: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !cursor_sel && rphase == 2'd2) |=> ridx == IDX_W'($past(ridx) + 1'b1)); // R4
  AST_RSEQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ($stable(rphase) && $stable(ridx))); // R5
  AST_CUR_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cursor_sel) |=> $stable(widx)); // R7
  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr == 2'd0 && cursor_sel) |=> $stable(pix_mask)); // R8
  AST_CMD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr == 2'd0 && !cursor_sel) |=> $stable(dac_cmd)); // R8
endmodule

bind pal_port pal_port_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .cursor_sel(cursor_sel), .rd_valid(rd_valid),
  .pix_mask(pix_mask), .dac_cmd(dac_cmd),
  .widx(widx), .wphase(wphase), .ridx(ridx), .rphase(rphase)
);

// File: tb/pal_port_bench.sv
module pal_port_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0, acc_wr = 1'b0, cursor_sel = 1'b0;
  logic [1:0] acc_addr = 2'd0;
  logic [7:0] acc_wdata = 8'd0;
  logic [7:0] rd_data, pix_mask, dac_cmd;
  logic       rd_valid;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pal_port u_pal_port (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .cursor_sel(cursor_sel),
    .rd_data(rd_data), .rd_valid(rd_valid), .pix_mask(pix_mask), .dac_cmd(dac_cmd)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    n_chk++;
    if (rd_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL R3 rd_valid got=%b exp=1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    chk("R1 rd_valid", {7'd0, rd_valid}, 8'd0);
    chk("R1 pix_mask", pix_mask, 8'hFF);
    chk("R1 dac_cmd", dac_cmd, 8'h00);
    rd_chk("R1 ridx", 2'd1, 8'd0);
    rd_chk("R1 widx", 2'd2, 8'd0);
    @(negedge clk);
    chk("R3 rd_valid drops", {7'd0, rd_valid}, 8'd0);
  endtask

  task automatic t_stream();
    wr(2'd2, 8'd5);
    wr(2'd3, 8'h11); wr(2'd3, 8'h22); wr(2'd3, 8'h33);
    wr(2'd3, 8'h44); wr(2'd3, 8'h55); wr(2'd3, 8'h66);
    rd_chk("R4 R9 widx after two entries", 2'd2, 8'd7);
    wr(2'd1, 8'd5);
    rd_chk("R3 red e5", 2'd3, 8'h11);
    rd_chk("R3 grn e5", 2'd3, 8'h22);
    rd_chk("R3 blu e5", 2'd3, 8'h33);
    rd_chk("R4 red e6", 2'd3, 8'h44);
    rd_chk("R4 grn e6", 2'd3, 8'h55);
    rd_chk("R4 blu e6", 2'd3, 8'h66);
    rd_chk("R9 ridx", 2'd1, 8'd7);
  endtask

  task automatic t_wrap();
    wr(2'd2, 8'd255);
    wr(2'd3, 8'hA0); wr(2'd3, 8'hA1); wr(2'd3, 8'hA2);
    rd_chk("R4 widx wrap", 2'd2, 8'd0);
    wr(2'd1, 8'd255);
    rd_chk("R2 red e255", 2'd3, 8'hA0);
    rd_chk("R2 grn e255", 2'd3, 8'hA1);
    rd_chk("R2 blu e255", 2'd3, 8'hA2);
    rd_chk("R4 ridx wrap", 2'd1, 8'd0);
  endtask

  task automatic t_interleave();
    wr(2'd2, 8'd10);
    wr(2'd3, 8'hB1);
    wr(2'd1, 8'd5);
    rd_chk("R5 read red", 2'd3, 8'h11);
    wr(2'd3, 8'hB2);
    rd_chk("R5 read grn", 2'd3, 8'h22);
    wr(2'd3, 8'hB3);
    rd_chk("R5 read blu", 2'd3, 8'h33);
    rd_chk("R5 ridx", 2'd1, 8'd6);
    rd_chk("R5 widx", 2'd2, 8'd11);
    wr(2'd1, 8'd10);
    rd_chk("R5 e10 red", 2'd3, 8'hB1);
    rd_chk("R5 e10 grn", 2'd3, 8'hB2);
    rd_chk("R5 e10 blu", 2'd3, 8'hB3);
  endtask

  task automatic t_restart();
    wr(2'd2, 8'd20);
    wr(2'd3, 8'h01); wr(2'd3, 8'h02);
    wr(2'd2, 8'd20);
    wr(2'd3, 8'h07); wr(2'd3, 8'h08); wr(2'd3, 8'h09);
    wr(2'd1, 8'd20);
    rd_chk("R2 restart red", 2'd3, 8'h07);
    rd(2'd3, acc_wdata);
    wr(2'd1, 8'd20);
    rd_chk("R3 reread red", 2'd3, 8'h07);
    rd_chk("R3 reread grn", 2'd3, 8'h08);
    rd_chk("R3 reread blu", 2'd3, 8'h09);
  endtask

  task automatic t_cursor();
    wr(2'd2, 8'd1);
    wr(2'd3, 8'h91); wr(2'd3, 8'h92); wr(2'd3, 8'h93);
    cursor_sel = 1'b1;
    wr(2'd2, 8'd0);
    wr(2'd3, 8'hE1); wr(2'd3, 8'hE2); wr(2'd3, 8'hE3);
    wr(2'd2, 8'd1);
    wr(2'd3, 8'hF1); wr(2'd3, 8'hF2); wr(2'd3, 8'hF3);
    wr(2'd3, 8'hF4);
    rd_chk("R7 widx held", 2'd2, 8'd1);
    wr(2'd1, 8'd2);
    rd_chk("R6 cur e0 red", 2'd3, 8'hE1);
    rd_chk("R6 cur e0 grn", 2'd3, 8'hE2);
    rd_chk("R6 cur e0 blu", 2'd3, 8'hE3);
    rd_chk("R7 cur e0 red again", 2'd3, 8'hE1);
    wr(2'd1, 8'd1);
    rd_chk("R7 cur e1 red rewritten", 2'd3, 8'hF4);
    rd_chk("R6 cur e1 grn", 2'd3, 8'hF2);
    rd_chk("R6 cur e1 blu", 2'd3, 8'hF3);
    cursor_sel = 1'b0;
    wr(2'd1, 8'd1);
    rd_chk("R6 main e1 red", 2'd3, 8'h91);
    rd_chk("R6 main e1 grn", 2'd3, 8'h92);
    rd_chk("R6 main e1 blu", 2'd3, 8'h93);
  endtask

  task automatic t_maskcmd();
    cursor_sel = 1'b0;
    wr(2'd0, 8'h3C);
    chk("R8 pix_mask", pix_mask, 8'h3C);
    chk("R8 cmd kept", dac_cmd, 8'h00);
    rd_chk("R8 read mask", 2'd0, 8'h3C);
    cursor_sel = 1'b1;
    wr(2'd0, 8'hA5);
    chk("R8 dac_cmd", dac_cmd, 8'hA5);
    chk("R8 mask kept", pix_mask, 8'h3C);
    rd_chk("R8 read cmd", 2'd0, 8'hA5);
    cursor_sel = 1'b0;
    rd_chk("R8 read mask again", 2'd0, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_wrap();
    t_interleave();
    t_restart();
    t_cursor();
    t_maskcmd();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule